// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local host bus and a backplane bus. It holds a set of programmable windows, eight by default. Every access the host presents is checked against all windows at once. When an access lands inside an enabled window, the block returns a complete description of the backplane cycle to issue. That description holds the translated remote address, the address-space size, the supervisor and program attributes, and the data width.

Software sets up each window through a write-only register port. Each window has four registers: a lower limit, an upper limit, an additive offset and a control word. When an access matches no window, the block reports a miss instead. All results are registered. They appear one clock after the access strobe.

Top module: `win_xlat_top`

## Requirements
- R1: After reset every window is disabled. Any access presented before configuration reports a miss.
- R2: Control bit 31 enables a window. Writing a control word with bit 31 clear disables that window, and later accesses no longer match it.
- R3: A window matches addresses `a` with base <= a < bound, both compared as unsigned 32-bit values. A window whose bound is not above its base matches nothing.
- R4: On a hit, `out_addr` equals the access address plus the matching window's offset, modulo 2^32.
- R5: Control bits 17:16 give `out_space`: 0 is 16-bit space, 1 is 24-bit space and 2 is 32-bit space. A window coded 3 never matches.
- R6: On a hit, `out_super` copies control bit 12 and `out_prog` copies control bit 14.
- R7: On a hit, `out_width` is 2 (32-bit data) when control bit 23 is set. It is 1 (16-bit) when only bit 22 is set, and 0 (8-bit) when both bits are clear. When both bits are set, bit 23 wins.
- R8: When several enabled windows match, the lowest-numbered one is chosen, and its index appears on `out_win`.
- R9: `out_valid` is high exactly in the cycle after a cycle with `acc_valid` high. In that cycle exactly one of `out_hit` and `out_miss` is high. Both are low when `out_valid` is low.
- R10: `cfg_addr` is {window index, select}, where select 0 is base, 1 is bound, 2 is offset and 3 is control. A write takes effect for accesses sampled on the next clock edge or later. An access sampled on the same edge as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NWIN)+2 | Window index (upper bits) and register select (low two bits) |
| cfg_wdata | input | AW | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | AW | Local access address |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_hit | output | 1 | Access matched a window |
| out_miss | output | 1 | Access matched no window |
| out_win | output | $clog2(NWIN) | Index of the selected window |
| out_addr | output | AW | Translated remote address |
| out_space | output | 2 | Address-space code |
| out_super | output | 1 | Supervisor cycle |
| out_prog | output | 1 | Program (not data) cycle |
| out_width | output | 2 | Data width code |

## Verification
A corrupted limit or offset register shows up at the next access near that window's edges. Such an access returns the wrong hit or miss answer, or the wrong translated address, one cycle after the strobe. The bench therefore probes both sides of every limit of every window. A wrong enable or priority state shows up as the wrong `out_win`, or as a wrong hit, on the first access into overlapping or just-disabled ranges. The bench builds those cases on purpose and probes them in the cycle right after each register write.

// File: rtl/wxl_pkg.sv
package wxl_pkg;

  localparam int CTL_EN_BIT  = 31;
  localparam int CTL_SP_LO   = 16;
  localparam int CTL_SUP_BIT = 12;
  localparam int CTL_PRG_BIT = 14;
  localparam int CTL_W32_BIT = 23;
  localparam int CTL_W16_BIT = 22;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_BOUND = 2'd1,
    SEL_OFFS  = 2'd2,
    SEL_CTRL  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SP_A16  = 2'd0,
    SP_A24  = 2'd1,
    SP_A32  = 2'd2,
    SP_RSVD = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    DW_8   = 2'd0,
    DW_16  = 2'd1,
    DW_32  = 2'd2,
    DW_UNU = 2'd3
  } width_e;

  typedef struct packed {
    logic   en;
    space_e space;
    logic   sup;
    logic   prg;
    width_e width;
  } win_attr_t;

  // Decode a control word once, at write time.
  function automatic win_attr_t decode_ctl(input logic [31:0] w);
    win_attr_t a;
    a.en    = w[CTL_EN_BIT];
    a.space = space_e'(w[CTL_SP_LO+1:CTL_SP_LO]);
    a.sup   = w[CTL_SUP_BIT];
    a.prg   = w[CTL_PRG_BIT];
    if (w[CTL_W32_BIT])
      a.width = DW_32;
    else if (w[CTL_W16_BIT])
      a.width = DW_16;
    else
      a.width = DW_8;
    return a;
  endfunction

endpackage

// File: rtl/wxl_regfile.sv
module wxl_regfile
  import wxl_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [IW+1:0]            cfg_addr,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [NWIN-1:0][AW-1:0]  base_o,
  output logic [NWIN-1:0][AW-1:0]  bound_o,
  output logic [NWIN-1:0][AW-1:0]  offs_o,
  output win_attr_t [NWIN-1:0]     attr_o
);

  logic [IW-1:0] wr_idx;
  reg_sel_e      wr_sel;

  assign wr_idx = cfg_addr[IW+1:2];
  assign wr_sel = reg_sel_e'(cfg_addr[1:0]);

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [AW-1:0] base_q;
    logic [AW-1:0] bound_q;
    logic [AW-1:0] offs_q;
    win_attr_t     attr_q;
    logic          wr_this;

    assign wr_this = cfg_we && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q  <= '0;
        bound_q <= '0;
        offs_q  <= '0;
        attr_q  <= '0;
      end else if (wr_this) begin
        case (wr_sel)
          SEL_BASE:  base_q  <= cfg_wdata;
          SEL_BOUND: bound_q <= cfg_wdata;
          SEL_OFFS:  offs_q  <= cfg_wdata;
          default:   attr_q  <= decode_ctl(cfg_wdata[31:0]);
        endcase
      end
    end

    assign base_o[g]  = base_q;
    assign bound_o[g] = bound_q;
    assign offs_o[g]  = offs_q;
    assign attr_o[g]  = attr_q;
  end

endmodule

// File: rtl/wxl_match.sv
module wxl_match
  import wxl_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [AW-1:0]            addr,
  input  logic [NWIN-1:0][AW-1:0]  base_i,
  input  logic [NWIN-1:0][AW-1:0]  bound_i,
  input  win_attr_t [NWIN-1:0]     attr_i,
  output logic [NWIN-1:0]          hit_vec,
  output logic                     any_hit,
  output logic [IW-1:0]            win_idx
);

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    logic above_base;
    logic below_bound;
    logic usable;

    assign above_base  = (addr >= base_i[g]);
    assign below_bound = (addr <  bound_i[g]);
    assign usable      = attr_i[g].en && (attr_i[g].space != SP_RSVD);
    assign hit_vec[g]  = usable && above_base && below_bound;
  end

  // Lowest index wins: scan from the top so the last write is the lowest.
  always_comb begin
    any_hit = |hit_vec;
    win_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IW'(i);
    end
  end

endmodule

// File: rtl/wxl_outreg.sv
module wxl_outreg
  import wxl_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  input  logic [AW-1:0]            acc_addr,
  input  logic                     any_hit,
  input  logic [IW-1:0]            win_idx,
  input  logic [NWIN-1:0][AW-1:0]  offs_i,
  input  win_attr_t [NWIN-1:0]     attr_i,
  output logic                     valid_q,
  output logic                     hit_q,
  output logic                     miss_q,
  output logic [IW-1:0]            win_q,
  output logic [AW-1:0]            addr_q,
  output win_attr_t                attr_q
);

  logic [AW-1:0] sel_offs;
  win_attr_t     sel_attr;
  logic          take;

  assign sel_offs = offs_i[win_idx];
  assign sel_attr = attr_i[win_idx];
  assign take     = acc_valid && any_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= acc_valid;
      hit_q   <= take;
      miss_q  <= acc_valid && !any_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      addr_q <= '0;
      attr_q <= '0;
    end else if (take) begin
      win_q  <= win_idx;
      addr_q <= acc_addr + sel_offs;
      attr_q <= sel_attr;
    end
  end

endmodule

// File: rtl/win_xlat_top.sv
module win_xlat_top
  import wxl_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [IW+1:0]   cfg_addr,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            acc_valid,
  input  logic [AW-1:0]   acc_addr,
  output logic            out_valid,
  output logic            out_hit,
  output logic            out_miss,
  output logic [IW-1:0]   out_win,
  output logic [AW-1:0]   out_addr,
  output logic [1:0]      out_space,
  output logic            out_super,
  output logic            out_prog,
  output logic [1:0]      out_width
);

  logic [NWIN-1:0][AW-1:0] base_w;
  logic [NWIN-1:0][AW-1:0] bound_w;
  logic [NWIN-1:0][AW-1:0] offs_w;
  win_attr_t [NWIN-1:0]    attr_w;
  logic [NWIN-1:0]         hit_vec;
  logic [NWIN-1:0]         en_vec;
  logic                    any_hit;
  logic [IW-1:0]           win_idx;
  win_attr_t               res_attr;

  for (genvar g = 0; g < NWIN; g++) begin : g_en
    assign en_vec[g] = attr_w[g].en;
  end

  wxl_regfile #(.NWIN(NWIN), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_w),
    .bound_o   (bound_w),
    .offs_o    (offs_w),
    .attr_o    (attr_w)
  );

  wxl_match #(.NWIN(NWIN), .AW(AW)) u_match (
    .addr    (acc_addr),
    .base_i  (base_w),
    .bound_i (bound_w),
    .attr_i  (attr_w),
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  wxl_outreg #(.NWIN(NWIN), .AW(AW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .any_hit   (any_hit),
    .win_idx   (win_idx),
    .offs_i    (offs_w),
    .attr_i    (attr_w),
    .valid_q   (out_valid),
    .hit_q     (out_hit),
    .miss_q    (out_miss),
    .win_q     (out_win),
    .addr_q    (out_addr),
    .attr_q    (res_attr)
  );

  assign out_space = res_attr.space;
  assign out_super = res_attr.sup;
  assign out_prog  = res_attr.prg;
  assign out_width = res_attr.width;

endmodule

// File: rtl/wxl_checker.sv
module wxl_checker #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [IW+1:0]   cfg_addr,
  input logic [AW-1:0]   cfg_wdata,
  input logic            acc_valid,
  input logic            out_valid,
  input logic            out_hit,
  input logic            out_miss,
  input logic [IW-1:0]   out_win,
  input logic [1:0]      out_space,
  input logic [NWIN-1:0] en_vec
);

  logic [NWIN-1:0] en_q;
  logic [IW-1:0]   last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      last_idx <= '0;
    end else begin
      en_q     <= en_vec;
      last_idx <= cfg_addr[IW+1:2];
    end
  end

  p_out_follows_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);

  p_out_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid);

  p_one_answer_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_hit ^ out_miss));

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_hit && !out_miss));

  p_reset_off_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_vec == '0));

  p_ctl_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr[1:0] == 2'd3 && !cfg_wdata[31]) |=> !en_vec[last_idx]);

  p_hit_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> en_q[out_win]);

  p_space_legal_r5: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (out_space != 2'b11));

endmodule

bind win_xlat_top wxl_checker #(.NWIN(NWIN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .acc_valid (acc_valid),
  .out_valid (out_valid),
  .out_hit   (out_hit),
  .out_miss  (out_miss),
  .out_win   (out_win),
  .out_space (out_space),
  .en_vec    (en_vec)
);

// File: tb/sim_win_xlat_top.sv
module sim_win_xlat_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic [31:0] acc_addr;
  logic        out_valid, out_hit, out_miss, out_super, out_prog;
  logic [2:0]  out_win;
  logic [31:0] out_addr;
  logic [1:0]  out_space, out_width;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_base [8];
  logic [31:0] m_bound[8];
  logic [31:0] m_off  [8];
  logic [31:0] m_ctl  [8];

  always #2 clk = ~clk;

  win_xlat_top #(.NWIN(8), .AW(32)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
    .out_win(out_win), .out_addr(out_addr), .out_space(out_space),
    .out_super(out_super), .out_prog(out_prog), .out_width(out_width)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int model_win(input logic [31:0] a);
    for (int i = 0; i < 8; i++) begin
      if (m_ctl[i][31] && m_ctl[i][17:16] != 2'b11 &&
          a >= m_base[i] && a < m_bound[i])
        return i;
    end
    return -1;
  endfunction

  task automatic wr(input int w, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {3'(w), 2'(sel)};
    cfg_wdata = d;
    case (sel)
      0: m_base[w]  = d;
      1: m_bound[w] = d;
      2: m_off[w]   = d;
      default: m_ctl[w] = d;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_acc(input logic [31:0] a, input string req);
    int w;
    logic [31:0] c;
    logic [31:0] ew;
    w = model_win(a);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R9", "valid", 32'(out_valid), 32'd1);
    if (w < 0) begin
      chk(req, "miss", 32'(out_miss), 32'd1);
      chk(req, "hit", 32'(out_hit), 32'd0);
    end else begin
      c  = m_ctl[w];
      ew = c[23] ? 32'd2 : (c[22] ? 32'd1 : 32'd0);
      chk(req, "hit", 32'(out_hit), 32'd1);
      chk(req, "win", 32'(out_win), 32'(w));
      chk("R4", "addr", out_addr, a + m_off[w]);
      chk("R5", "space", 32'(out_space), 32'(c[17:16]));
      chk("R6", "super", 32'(out_super), 32'(c[12]));
      chk("R6", "prog", 32'(out_prog), 32'(c[14]));
      chk("R7", "width", 32'(out_width), ew);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] ctl;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_bound[i] = 0; m_off[i] = 0; m_ctl[i] = 0;
    end
    repeat (4) @(negedge clk);
    chk("R1", "valid in reset", 32'(out_valid), 32'd0);
    chk("R1", "hit in reset", 32'(out_hit), 32'd0);
    rst = 1'b0;

    // R1: nothing matches before configuration
    for (int i = 0; i < 8; i++) do_acc(32'h1000_0000 * i + 32'h120, "R1");

    // R9: out_valid drops in the cycle after an idle strobe
    @(negedge clk);
    chk("R9", "idle", 32'(out_valid), 32'd0);

    // Configure eight disjoint windows with varied attributes (R10 layout)
    for (int i = 0; i < 8; i++) begin
      ctl = 32'h8000_0000;
      ctl[17:16] = (i == 7) ? 2'b11 : 2'(i % 3);
      ctl[12] = i[0];
      ctl[14] = i[1];
      ctl[22] = i[0];
      ctl[23] = i[1];
      wr(i, 0, 32'h1000_0000 * i + 32'h100);
      wr(i, 1, 32'h1000_0000 * i + 32'h100 + 32'h40 * (i + 1));
      wr(i, 2, 32'h0123_4567 * (i + 1));
      wr(i, 3, ctl);
    end

    // R3 edge sweep on every window (window 7 has reserved space: R5)
    for (int i = 0; i < 8; i++) begin
      do_acc(m_base[i] - 1, "R3");
      do_acc(m_base[i], "R3");
      do_acc(m_base[i] + 1, "R3");
      do_acc(m_bound[i] - 1, "R3");
      do_acc(m_bound[i], "R3");
      do_acc(m_base[i] + (m_bound[i] - m_base[i]) / 2, (i == 7) ? "R5" : "R3");
    end

    // R8: window 5 overlaps window 2; lowest index wins
    wr(5, 0, m_base[2]);
    wr(5, 1, m_bound[2]);
    do_acc(m_base[2] + 4, "R8");
    chk("R8", "low index", 32'(out_win), 32'd2);

    // R2: disabling window 2 exposes window 5
    wr(2, 3, 32'h0000_0000);
    do_acc(m_base[2] + 4, "R2");
    chk("R2", "after disable", 32'(out_win), 32'd5);

    // R3: empty window (bound == base)
    wr(3, 1, m_base[3]);
    do_acc(m_base[3], "R3");

    // R4: offset wraps modulo 2^32
    wr(1, 2, 32'hF000_0000);
    do_acc(m_base[1] + 8, "R4");
    chk("R4", "wrap", out_addr, 32'h0000_0108);

    // R7: both width bits set gives 32-bit
    wr(4, 3, 32'h80C2_0000);
    do_acc(m_base[4], "R7");
    chk("R7", "both width bits", 32'(out_width), 32'd2);

    // R10: access on the same edge as a control write sees the old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'd0, 2'd3}; cfg_wdata = 32'h0;
    acc_valid = 1'b1; acc_addr = m_base[0];
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R10", "old setting hit", 32'(out_hit), 32'd1);
    chk("R10", "old setting win", 32'(out_win), 32'd0);
    m_ctl[0] = 32'h0;
    do_acc(m_base[0], "R10");
    chk("R10", "new setting miss", 32'(out_miss), 32'd1);

    summary();
    $finish;
  end

endmodule